// File: doc/BRIEF.md
# Indexed configuration port with logical-device banks

This block is a legacy-style configuration register file that a host reaches through two byte-wide I/O addresses on a simple parallel bus. One address is the index port and the other is the data port. The host first writes a register number to the index port, then reads or writes that register through the data port. Set and clear of single bits are done by read-modify-write, so every writable register reads back the last value written.

Access is guarded by a key sequence. The enter key must be written to the index port twice in a row before any register can be reached. A single exit key locks the block again. While it is unlocked, a global selector register picks one logical device. The per-device registers then address that device's bank. Each bank holds an enable byte, a 16-bit base address written as two bytes, and an interrupt-select byte. The block drives these values out to the devices it configures. Two read-only global register pairs identify the chip and the vendor.

A strap input picks which of two address pairs the ports use. An address that the block does not decode reads as a floating bus.

Top module: `sio_cfg_port`

## Requirements
- R1: The block unlocks only after the enter key 0x87 has been written to the index port on two consecutive index-port writes. After a single 0x87, data-port reads still return 0xFF.
- R2: Any index-port byte other than 0x87 written after a first 0x87 restarts the key sequence. For example, 0x87, 0x55, 0x87 leaves the block locked, and one more 0x87 then unlocks it.
- R3: While unlocked, a write of 0x AA to the index port locks the block again and does not change the index.
- R4: While locked, every read of either port returns 0xFF, and writes to the data port change no register.
- R5: With port_sel=0 the index and data ports are 0x002E and 0x002F. With port_sel=1 they are 0x004E and 0x004F. Reads at any other address return 0xFF, and writes there (key bytes included) have no effect.
- R6: While unlocked, an index-port write other than 0xAA stores the index, and an index-port read returns the stored index.
- R7: Index 0x07 holds the logical device number, which reads back. It selects which bank the per-device indexes reach, and each bank keeps its own values.
- R8: The per-device indexes are enable 0x30, base high byte 0x60, base low byte 0x61 and interrupt select 0x70. Each reads back the full byte last written. Bit 0 of the enable byte drives dev_en[d]. dev_base[16d+15:16d] is {high,low} and dev_irq[8d+7:8d] is the interrupt byte.
- R9: Indexes 0x20/0x21 return CHIP_ID high/low and 0x22/0x23 return VENDOR_ID high/low. Writes to them have no effect.
- R10: When the logical device number is NUM_DEV or more, the per-device indexes read 0xFF and writes to them are ignored.
- R11: Reset leaves the block locked with index 0, device number 0 and every bank register 0. All dev_en bits are therefore clear.
- R12: io_rdata takes the read value on the clock edge that samples io_rd and holds it until the next read. Indexes with no register read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_sel | input | 1 | Port pair strap: 0 selects 0x2E/0x2F, 1 selects 0x4E/0x4F |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | High while the block is unlocked |
| dev_en | output | NUM_DEV | Per-device enable, bit 0 of each enable byte |
| dev_base | output | 16*NUM_DEV | Per-device base address, 16 bits per device |
| dev_irq | output | 8*NUM_DEV | Per-device interrupt-select byte |

## Verification
The bench targets how the key sequence breaks down. It tries a single enter key, a stray byte between two enter keys, and an exit key written while the sequence is only half entered. A design that counted any two enter keys, or that ignored an interruption, would unlock early. The bench also swaps the port strap so that keys land on the undecoded pair, and it selects a device number past the last bank. A design that decoded too few address bits, or that aliased out-of-range device numbers, would change a real bank there. Long random runs mix locking, reselecting and read-modify-write traffic. They catch a bank write that goes to the wrong device, or a register that fails to read back what was written.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_ENTER   = 8'h87;
  localparam logic [7:0] KEY_EXIT    = 8'hAA;
  localparam logic [7:0] BUS_FLOAT   = 8'hFF;

  localparam logic [7:0] IX_LDN      = 8'h07;
  localparam logic [7:0] IX_CHIP_HI  = 8'h20;
  localparam logic [7:0] IX_CHIP_LO  = 8'h21;
  localparam logic [7:0] IX_VEND_HI  = 8'h22;
  localparam logic [7:0] IX_VEND_LO  = 8'h23;
  localparam logic [7:0] IX_DEV_EN   = 8'h30;
  localparam logic [7:0] IX_BASE_HI  = 8'h60;
  localparam logic [7:0] IX_BASE_LO  = 8'h61;
  localparam logic [7:0] IX_IRQ      = 8'h70;

  function automatic logic is_dev_index(input logic [7:0] ix);
    return (ix == IX_DEV_EN) || (ix == IX_BASE_HI) ||
           (ix == IX_BASE_LO) || (ix == IX_IRQ);
  endfunction

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode #(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] BASE_A = 16'h002E,
  parameter logic [15:0] BASE_B = 16'h004E
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              port_sel,
  output logic              hit_idx,
  output logic              hit_dat
);
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_A);
  localparam logic [ADDR_W-1:0] IDX_B = ADDR_W'(BASE_B);

  logic [ADDR_W-1:0] idx_addr;

  always_comb begin
    idx_addr = port_sel ? IDX_B : IDX_A;
    hit_idx  = (io_addr == idx_addr);
    hit_dat  = (io_addr == idx_addr + ADDR_W'(1));
  end

endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       open
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      unique case (state_q)
        KS_LOCKED: state_d = (key_data == KEY_ENTER) ? KS_HALF : KS_LOCKED;
        KS_HALF:   state_d = (key_data == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   state_d = (key_data == KEY_EXIT)  ? KS_LOCKED : KS_OPEN;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open = (state_q == KS_OPEN);

  // R1: opening is always preceded by a half-entered sequence plus a second key
  a_r1_open_needs_two_keys: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(state_q == KS_HALF && key_wr && key_data == KEY_ENTER));

  // R2: a stray byte after the first key drops back to locked
  a_r2_stray_byte_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_HALF && key_wr && key_data != KEY_ENTER) |=> !open && state_q == KS_LOCKED);

  // R3: exit key closes the port
  a_r3_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (open && key_wr && key_data == KEY_EXIT) |=> !open);

endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            ldn,
  input  logic [7:0]            reg_idx,
  input  logic [7:0]            wdata,
  output logic [7:0]            rd_data,
  output logic [NUM_DEV-1:0]    dev_en,
  output logic [16*NUM_DEV-1:0] dev_base,
  output logic [8*NUM_DEV-1:0]  dev_irq
);
  localparam logic [7:0] LDN_LIMIT = 8'(NUM_DEV);

  logic [7:0] en_q  [NUM_DEV];
  logic [7:0] bhi_q [NUM_DEV];
  logic [7:0] blo_q [NUM_DEV];
  logic [7:0] irq_q [NUM_DEV];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic       sel;
    logic [7:0] en_d, bhi_d, blo_d, irq_d;

    always_comb begin
      sel   = wr_en && (ldn == 8'(d));
      en_d  = en_q[d];
      bhi_d = bhi_q[d];
      blo_d = blo_q[d];
      irq_d = irq_q[d];
      if (sel) begin
        unique case (reg_idx)
          IX_DEV_EN:  en_d  = wdata;
          IX_BASE_HI: bhi_d = wdata;
          IX_BASE_LO: blo_d = wdata;
          IX_IRQ:     irq_d = wdata;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[d]  <= '0;
        bhi_q[d] <= '0;
        blo_q[d] <= '0;
        irq_q[d] <= '0;
      end else if (sel) begin
        en_q[d]  <= en_d;
        bhi_q[d] <= bhi_d;
        blo_q[d] <= blo_d;
        irq_q[d] <= irq_d;
      end
    end

    assign dev_en[d]              = en_q[d][0];
    assign dev_base[16*d +: 16]   = {bhi_q[d], blo_q[d]};
    assign dev_irq[8*d +: 8]      = irq_q[d];
  end

  always_comb begin
    rd_data = BUS_FLOAT;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (ldn == 8'(d)) begin
        unique case (reg_idx)
          IX_DEV_EN:  rd_data = en_q[d];
          IX_BASE_HI: rd_data = bhi_q[d];
          IX_BASE_LO: rd_data = blo_q[d];
          IX_IRQ:     rd_data = irq_q[d];
          default:    rd_data = 8'h00;
        endcase
      end
    end
  end

  // R10: a device number past the last bank never alters any bank
  a_r10_bad_ldn_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ldn >= LDN_LIMIT) |=> $stable(dev_base) && $stable(dev_irq) && $stable(dev_en));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_DEV   = 8,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] CHIP_ID   = 16'h0A52,
  parameter logic [15:0] VENDOR_ID = 16'h19C3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  port_sel,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic                  cfg_open,
  output logic [NUM_DEV-1:0]    dev_en,
  output logic [16*NUM_DEV-1:0] dev_base,
  output logic [8*NUM_DEV-1:0]  dev_irq
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic hit_idx, hit_dat;

  sio_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .io_addr  (io_addr),
    .port_sel (port_sel),
    .hit_idx  (hit_idx),
    .hit_dat  (hit_dat)
  );

  logic key_wr;
  assign key_wr = io_wr && hit_idx;

  sio_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .key_wr   (key_wr),
    .key_data (io_wdata),
    .open     (cfg_open)
  );

  logic [7:0] index_q, index_d;
  logic [7:0] ldn_q, ldn_d;
  logic [7:0] rdata_q, rdata_d;
  logic       dat_wr, bank_wr;
  logic [7:0] bank_rd;
  logic [7:0] rd_val;

  always_comb begin
    dat_wr  = io_wr && hit_dat && cfg_open;
    bank_wr = dat_wr && is_dev_index(index_q);
    index_d = index_q;
    ldn_d   = ldn_q;
    if (key_wr && cfg_open && io_wdata != KEY_EXIT) index_d = io_wdata;
    if (dat_wr && index_q == IX_LDN)                ldn_d   = io_wdata;
  end

  sio_dev_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (bank_wr),
    .ldn      (ldn_q),
    .reg_idx  (index_q),
    .wdata    (io_wdata),
    .rd_data  (bank_rd),
    .dev_en   (dev_en),
    .dev_base (dev_base),
    .dev_irq  (dev_irq)
  );

  always_comb begin
    rd_val = BUS_FLOAT;
    if (cfg_open && hit_idx) begin
      rd_val = index_q;
    end else if (cfg_open && hit_dat) begin
      unique case (index_q)
        IX_LDN:     rd_val = ldn_q;
        IX_CHIP_HI: rd_val = CHIP_ID[15:8];
        IX_CHIP_LO: rd_val = CHIP_ID[7:0];
        IX_VEND_HI: rd_val = VENDOR_ID[15:8];
        IX_VEND_LO: rd_val = VENDOR_ID[7:0];
        IX_DEV_EN, IX_BASE_HI, IX_BASE_LO, IX_IRQ: rd_val = bank_rd;
        default:    rd_val = 8'h00;
      endcase
    end
    rdata_d = io_rd ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      index_q <= '0;
      ldn_q   <= '0;
      rdata_q <= BUS_FLOAT;
    end else begin
      index_q <= index_d;
      ldn_q   <= ldn_d;
      rdata_q <= rdata_d;
    end
  end

  assign io_rdata = rdata_q;

  // R4: locked reads float
  a_r4_locked_read_floats: assert property (@(posedge clk) disable iff (!rst_core_n)
    (io_rd && !cfg_open) |=> io_rdata == BUS_FLOAT);

  // R4: locked cycles leave every bank output untouched
  a_r4_locked_no_change: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cfg_open |=> $stable(dev_en) && $stable(dev_base) && $stable(dev_irq));

  // R5: undecoded addresses float
  a_r5_foreign_read_floats: assert property (@(posedge clk) disable iff (!rst_core_n)
    (io_rd && !hit_idx && !hit_dat) |=> io_rdata == BUS_FLOAT);

  // R12: read data holds between reads
  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_core_n)
    !io_rd |=> $stable(io_rdata));

  // R3: the exit key never lands in the index register
  a_r3_exit_keeps_index: assert property (@(posedge clk) disable iff (!rst_core_n)
    (key_wr && io_wdata == KEY_EXIT) |=> $stable(index_q));

endmodule

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
  localparam int          NUM_DEV   = 8;
  localparam int          ADDR_W    = 16;
  localparam logic [15:0] CHIP_ID   = 16'h0A52;
  localparam logic [15:0] VENDOR_ID = 16'h19C3;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  port_sel;
  logic [ADDR_W-1:0]     io_addr;
  logic                  io_wr, io_rd;
  logic [7:0]            io_wdata;
  logic [7:0]            io_rdata;
  logic                  cfg_open;
  logic [NUM_DEV-1:0]    dev_en;
  logic [16*NUM_DEV-1:0] dev_base;
  logic [8*NUM_DEV-1:0]  dev_irq;

  always #2 clk = ~clk;

  sio_cfg_port #(
    .NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID), .VENDOR_ID(VENDOR_ID)
  ) u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_open(cfg_open), .dev_en(dev_en), .dev_base(dev_base), .dev_irq(dev_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model, built from the requirements
  int         m_state;
  logic [7:0] m_idx, m_ldn;
  logic [7:0] m_en [NUM_DEV];
  logic [7:0] m_bh [NUM_DEV];
  logic [7:0] m_bl [NUM_DEV];
  logic [7:0] m_irq[NUM_DEV];

  function automatic logic [15:0] idx_port();
    return port_sel ? 16'h004E : 16'h002E;
  endfunction

  function automatic void model_reset();
    m_state = 0; m_idx = 8'h00; m_ldn = 8'h00;
    for (int d = 0; d < NUM_DEV; d++) begin
      m_en[d] = 0; m_bh[d] = 0; m_bl[d] = 0; m_irq[d] = 0;
    end
  endfunction

  function automatic void model_write(logic [15:0] a, logic [7:0] v);
    if (a == idx_port()) begin
      case (m_state)
        0: m_state = (v == 8'h87) ? 1 : 0;
        1: m_state = (v == 8'h87) ? 2 : 0;
        default: if (v == 8'hAA) m_state = 0; else m_idx = v;
      endcase
    end else if (a == idx_port() + 16'd1 && m_state == 2) begin
      if (m_idx == 8'h07) m_ldn = v;
      else if (m_ldn < NUM_DEV) begin
        case (m_idx)
          8'h30: m_en[m_ldn]  = v;
          8'h60: m_bh[m_ldn]  = v;
          8'h61: m_bl[m_ldn]  = v;
          8'h70: m_irq[m_ldn] = v;
          default: ;
        endcase
      end
    end
  endfunction

  function automatic logic [7:0] model_read(logic [15:0] a);
    if (a != idx_port() && a != idx_port() + 16'd1) return 8'hFF;
    if (m_state != 2) return 8'hFF;
    if (a == idx_port()) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return CHIP_ID[15:8];
      8'h21: return CHIP_ID[7:0];
      8'h22: return VENDOR_ID[15:8];
      8'h23: return VENDOR_ID[7:0];
      8'h30: return (m_ldn < NUM_DEV) ? m_en[m_ldn]  : 8'hFF;
      8'h60: return (m_ldn < NUM_DEV) ? m_bh[m_ldn]  : 8'hFF;
      8'h61: return (m_ldn < NUM_DEV) ? m_bl[m_ldn]  : 8'hFF;
      8'h70: return (m_ldn < NUM_DEV) ? m_irq[m_ldn] : 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [15:0] a, logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(a, v);
  endtask

  task automatic do_rd(logic [15:0] a, string req);
    logic [7:0] exp;
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    exp = model_read(a);
    @(negedge clk);
    io_rd = 1'b0;
    check(req, {24'h0, io_rdata}, {24'h0, exp});
  endtask

  task automatic check_outputs(string req);
    for (int d = 0; d < NUM_DEV; d++) begin
      check(req, {31'h0, dev_en[d]}, {31'h0, m_en[d][0]});
      check(req, {16'h0, dev_base[16*d +: 16]}, {16'h0, m_bh[d], m_bl[d]});
      check(req, {24'h0, dev_irq[8*d +: 8]}, {24'h0, m_irq[d]});
    end
    check(req, {31'h0, cfg_open}, {31'h0, (m_state == 2)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_reg(logic [7:0] ix, logic [7:0] v);
    do_wr(idx_port(), ix);
    do_wr(idx_port() + 16'd1, v);
  endtask

  task automatic read_reg(logic [7:0] ix, string req);
    do_wr(idx_port(), ix);
    do_rd(idx_port() + 16'd1, req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin : stim
    logic [7:0] pick_ix [10];
    int unsigned r;
    pick_ix = '{8'h07, 8'h20, 8'h21, 8'h22, 8'h23, 8'h30, 8'h60, 8'h61, 8'h70, 8'h10};
    port_sel = 0; io_addr = 0; io_wr = 0; io_rd = 0; io_wdata = 0; rst_n = 1;
    r = $urandom(32'd5120);
    do_reset();

    // R11: reset state
    check_outputs("R11");
    do_rd(16'h002F, "R4");
    do_rd(16'h002E, "R4");

    // R1: one key is not enough
    do_wr(16'h002E, 8'h87);
    check("R1", {31'h0, cfg_open}, 32'h0);
    do_rd(16'h002F, "R1");
    do_wr(16'h002E, 8'h87);
    check("R1", {31'h0, cfg_open}, 32'h1);
    do_rd(16'h002E, "R6");               // index 0 after reset (R11)
    read_reg(8'h20, "R9");
    read_reg(8'h21, "R9");
    read_reg(8'h22, "R9");
    read_reg(8'h23, "R9");
    set_reg(8'h21, 8'h00);
    read_reg(8'h21, "R9");

    // R7/R8: two banks hold separate values
    set_reg(8'h07, 8'h02);
    set_reg(8'h30, 8'h01); set_reg(8'h60, 8'h03); set_reg(8'h61, 8'hF8); set_reg(8'h70, 8'h04);
    set_reg(8'h07, 8'h05);
    set_reg(8'h30, 8'hFE); set_reg(8'h60, 8'h02); set_reg(8'h61, 8'hE8); set_reg(8'h70, 8'h0B);
    read_reg(8'h07, "R7");
    read_reg(8'h30, "R8");
    set_reg(8'h07, 8'h02);
    read_reg(8'h61, "R7");
    check_outputs("R8");

    // R12: unassigned index, and hold between reads
    read_reg(8'h10, "R12");
    repeat (3) @(negedge clk);
    check("R12", {24'h0, io_rdata}, 32'h0);

    // R10: device number out of range
    set_reg(8'h07, 8'(NUM_DEV + 1));
    set_reg(8'h60, 8'h55);
    read_reg(8'h60, "R10");
    check_outputs("R10");

    // R3: exit locks, index kept
    do_wr(16'h002E, 8'hAA);
    check("R3", {31'h0, cfg_open}, 32'h0);
    set_reg(8'h30, 8'h01);           // R4: locked writes ignored
    check_outputs("R4");

    // R2: stray byte restarts the sequence
    do_wr(16'h002E, 8'h87); do_wr(16'h002E, 8'h55); do_wr(16'h002E, 8'h87);
    check("R2", {31'h0, cfg_open}, 32'h0);
    do_wr(16'h002E, 8'h87);
    check("R2", {31'h0, cfg_open}, 32'h1);
    do_rd(16'h002E, "R3");

    // R5: alternate port pair
    port_sel = 1;
    do_rd(16'h002E, "R5");
    do_wr(16'h002E, 8'hAA);
    check("R5", {31'h0, cfg_open}, 32'h1);
    do_rd(16'h004F, "R5");
    do_rd(16'h014E, "R5");
    port_sel = 0;

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      r = $urandom;
      port_sel = (r[31:28] == 4'h0) ? ~port_sel : port_sel;
      case (r[3:0])
        0, 1: do_wr(idx_port(), (r[4] ? 8'h87 : (r[5] ? 8'hAA : r[15:8])));
        2, 3, 4: do_wr(idx_port(), pick_ix[r[11:8] % 10]);
        5: do_wr(idx_port() + 16'd1, {5'h0, r[14:12]} + (r[15] ? 8'd6 : 8'd0));
        6, 7, 8: do_wr(idx_port() + 16'd1, r[23:16]);
        9, 10, 11: do_rd(idx_port() + 16'd1, "R8");
        12: do_rd(idx_port(), "R6");
        13: do_rd(16'h0080 ^ idx_port(), "R5");
        14: do_wr(16'h0060 ^ idx_port(), r[4] ? 8'h87 : 8'hAA);
        default: if (r[20:8] == 0) do_reset(); else do_rd(idx_port() + 16'd1, "R4");
      endcase
      if (n % 256 == 255) check_outputs("R8");
    end

    do_reset();
    check_outputs("R11");
    do_rd(16'h002F, "R11");

    done = 1;
    finish_run();
  end

endmodule